// File: doc/BRIEF.md
# Split-Read Timestamp Counter

This block is a free-running timestamp counter, 40 bits wide by default. It advances by one on every cycle where its tick enable input is high and counting is enabled. It has no interrupt output. The tick enable is generated outside the block and stands for a slow time base of roughly 983 kHz.

Software reads the count through a 32-bit register bus in two accesses. It reads the low-word register first. That access returns the lower bits of the count and, on the same clock edge, copies the upper bits into a holding register. It then reads the high register, which returns that held copy. The two halves therefore always come from the same instant, even if the counter carries between the two accesses. The high register also holds the enable control. The combined value is taken modulo 2^40.

Top module: `split_read_stamp`

## Requirements
- R1: While reset is asserted and after it is released, the count is zero, counting is disabled and the held upper bits are zero.
- R2: On a clock edge where counting is enabled and `tick_en` is high, the count increases by exactly one. On any other edge it holds its value.
- R3: When the count is all ones and it advances, it becomes zero.
- R4: A read at offset 0x60 (the low word) returns the count bits below `LO_W` in the same cycle, zero-extended to the bus width. These are the bits before any increment at the end of that cycle.
- R5: The clock edge that ends a low-word read copies the count's upper bits (`LO_W` and up) into the holding register. The copied bits are the ones present during that read, even if the counter advances on the same edge.
- R6: A read at offset 0x64 (the high register) returns the held upper bits in bits `HI_W-1:0`, the enable in bit 8 and zero in every other bit. The held bits change only on a low-word read.
- R7: A write at offset 0x64 sets the enable to bit 8 of the write data. All other write data bits are ignored, and the held upper bits are not affected.
- R8: A write at offset 0x60 has no effect on the count, the enable or the held bits.
- R9: `rdata` is zero when `rd_en` is low or when the read address is neither 0x60 nor 0x64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance strobe |
| rd_en | input | 1 | Read access this cycle |
| wr_en | input | 1 | Write access this cycle |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
The assertions check on every cycle that the count holds unless it is enabled and ticked, that it wraps from all ones to zero, that the held bits change only on a low-word read and then take the pre-edge upper bits, that the enable changes only on a high-register write, and that idle or unmapped reads return zero. Some behaviour can only be shown by the bench's scenarios in a small configuration with a 12-bit count and an 8-bit low word. These are: that a low-then-high pair reassembles the exact count at every one of the 4096 values across a full wrap, including the carry edges, and that writes with stray data bits leave the held bits and the count untouched.

// File: rtl/split_read_stamp.sv
module split_read_stamp #(
  parameter int CNT_W   = 40,
  parameter int LO_W    = 32,
  parameter int BUS_W   = 32,
  parameter int EN_POS  = 8,
  parameter logic [7:0] LO_OFS = 8'h60,
  parameter logic [7:0] HI_OFS = 8'h64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  localparam int HI_W = CNT_W - LO_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_hold;
  logic             run;

  wire lo_rd  = rd_en && (addr == LO_OFS);
  wire hi_rd  = rd_en && (addr == HI_OFS);
  wire hi_wr  = wr_en && (addr == HI_OFS);
  wire adv    = run && tick_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      hi_hold <= '0;
      run     <= 1'b0;
    end else begin
      if (adv)   cnt     <= cnt + CNT_W'(1);
      if (lo_rd) hi_hold <= cnt[CNT_W-1:LO_W];
      if (hi_wr) run     <= wdata[EN_POS];
    end
  end

  logic [BUS_W-1:0] lo_view, hi_view;
  always_comb begin
    lo_view = '0;
    lo_view[LO_W-1:0] = cnt[LO_W-1:0];
    hi_view = '0;
    hi_view[HI_W-1:0] = hi_hold;
    hi_view[EN_POS] = run;
  end

  assign rdata = lo_rd ? lo_view : (hi_rd ? hi_view : '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && tick_en) |=> $stable(cnt));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && (&cnt)) |=> (cnt == '0));
  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == LO_OFS) |=> (hi_hold == $past(cnt[CNT_W-1:LO_W])));
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == LO_OFS) |=> $stable(hi_hold));
  p_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == HI_OFS) |=> $stable(run));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
  p_unmap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != LO_OFS && addr != HI_OFS) |-> (rdata == '0));
endmodule

// File: tb/sim_split_read_stamp.sv
module sim_split_read_stamp;
  localparam int CLK_P = 10;
  localparam int CW = 12;
  localparam int LW = 8;
  localparam int HW = CW - LW;
  localparam logic [7:0] LO = 8'h60;
  localparam logic [7:0] HI = 8'h64;

  logic clk = 0, rst_n = 0, tick_en = 0, rd_en = 0, wr_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  split_read_stamp #(.CNT_W(CW), .LO_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [CW-1:0] m_cnt = '0;
  logic [HW-1:0] m_hold = '0;
  logic m_en = 0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] hi_exp();
    logic [31:0] v = '0;
    v[HW-1:0] = m_hold;
    v[8] = m_en;
    return v;
  endfunction

  task automatic acc(input logic t, input logic r, input logic w, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] got);
    @(negedge clk);
    tick_en = t; rd_en = r; wr_en = w; addr = a; wdata = d;
    #1 got = rdata;
    @(posedge clk);
    if (r && a == LO) m_hold = m_cnt[CW-1:LW];
    if (m_en && t) m_cnt = m_cnt + 1'b1;
    if (w && a == HI) m_en = d[8];
  endtask

  task automatic pair(input string req, input logic t);
    logic [31:0] g, exp;
    exp = 32'(m_cnt[LW-1:0]);
    acc(t, 1, 0, LO, 0, g);
    check(req, g, exp);
    acc(0, 1, 0, HI, 0, g);
    check(req, g, hi_exp());
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] g;
    logic [CW-1:0] snap;
    // R1 reset state
    rd_en = 1; addr = HI; tick_en = 1;
    repeat (3) @(posedge clk);
    #1 check("R1 high", rdata, 32'h0);
    addr = LO; #1 check("R1 low", rdata, 32'h0);
    @(negedge clk); rst_n = 1; rd_en = 0; tick_en = 0;
    pair("R1 after release", 1);
    // R2 disabled: ticks ignored
    repeat (10) acc(1, 0, 0, 8'h00, 0, g);
    pair("R2 disabled", 0);
    // R7 enable with stray bits
    acc(0, 0, 1, HI, 32'hFFFF_FFFF, g);
    check("R9 idle read", g, 32'h0);
    pair("R7 enable", 0);
    // R2/R3/R4/R5/R6 full sweep across wrap
    for (int i = 0; i < (1 << CW) + 8; i++) begin
      snap = m_cnt;
      pair((snap[LW-1:0] == '1) ? "R5 carry" : ((snap == '1) ? "R3 wrap" : "R4"), 1);
    end
    // R2 idle cycles without tick
    repeat (5) acc(0, 0, 0, 8'h00, 0, g);
    pair("R2 no tick", 0);
    // R8 write low ignored
    acc(1, 0, 1, LO, 32'hFFFF_FFFF, g);
    pair("R8 write low", 0);
    // R7 disable with other bits set: hold untouched
    acc(0, 0, 1, HI, 32'hFFFF_FEFF, g);
    acc(0, 1, 0, HI, 0, g);
    check("R7 disable", g, hi_exp());
    repeat (6) acc(1, 0, 0, 8'h00, 0, g);
    pair("R2 after disable", 1);
    // R9 unmapped
    acc(0, 1, 0, 8'h68, 0, g);
    check("R9 unmapped", g, 32'h0);
    acc(0, 1, 0, 8'h61, 0, g);
    check("R9 unmapped", g, 32'h0);
    // R6 hold stays across counting
    acc(0, 0, 1, HI, 32'h100, g);
    pair("R6 setup", 1);
    repeat (300) acc(1, 0, 0, 8'h00, 0, g);
    acc(0, 1, 0, HI, 0, g);
    check("R6 hold stable", g, hi_exp());
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule